// File: doc/BRIEF.md
# Pulse-Count Packet Transmitter

This block sends a short fixed-format message over one wire. It does not shift out bits. Each byte value N is sent as a burst of N identical pulses inside a time slot of its own. After a start request the block first emits a constant wake-up burst of five pulses. It then sends the five value slots in turn: three data bytes followed by two checksum bytes. All timing is derived from the system clock through a clock-enable divider, so the pulse rate and the slot lengths stay exact for any clock frequency that divides evenly.

The user supplies the five byte values, and the checksum bytes are among them. The block samples all five values in the cycle the start request is accepted. A busy flag covers the whole message. A one-cycle done strobe marks its end. Elaboration stops with an error if the clock frequency does not divide exactly into pulse half-periods, or if a full burst could not fit inside its slot.

Top module: `pcount_tx`

## Requirements
- R1: After reset, `line_o`, `busy_o` and `done_o` are all low.
- R2: A high `start_i` while `busy_o` is low is accepted at that clock edge. `busy_o` is high from the next cycle for exactly 4940 pulse half-periods (1235 ms), and low again after that.
- R3: The message opens with a wake-up slot holding exactly 5 pulses, the first one starting in the cycle after acceptance.
- R4: Every pulse is high for one half-period (0.25 ms) and then low for one half-period, giving a 2 kHz rate. The pulses of a burst follow back to back from the start of their slot.
- R5: The first value slot starts 940 half-periods (235 ms) after the start of the wake-up slot.
- R6: Each further slot starts 800 half-periods (200 ms) after the previous one. The value slots carry, in order, `dat0_i`, `dat1_i`, `dat2_i`, `sum0_i` and `sum1_i`.
- R7: A value N (0..255) yields exactly N pulses in its slot. A value of 0 gives none, yet its slot keeps its full length. A value of 255 still fits inside its slot.
- R8: `line_o` is low in every gap after a burst and whenever `busy_o` is low.
- R9: A `start_i` that arrives while `busy_o` is high is ignored. Changes on the byte inputs during a message have no effect on it, because the values are captured at acceptance.
- R10: `done_o` is high for exactly one cycle, which is the first cycle with `busy_o` low after the final slot ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency given by parameter CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send one message |
| dat0_i | input | 8 | First data value (pulse count) |
| dat1_i | input | 8 | Second data value |
| dat2_i | input | 8 | Third data value |
| sum0_i | input | 8 | First checksum value |
| sum1_i | input | 8 | Second checksum value |
| line_o | output | 1 | Serial pulse output |
| busy_o | output | 1 | Message in progress |
| done_o | output | 1 | One-cycle strobe at message end |

## Verification
The hardest case to reach from the ports is a second start request arriving inside a running message while the byte inputs also change. Only the full cycle-by-cycle waveform shows whether the message was restarted or its values were picked up again. The bench raises `start_i` and scrambles all five byte inputs at chosen points mid-message, including the last busy cycle. It then compares every cycle of `line_o` against a waveform computed from the values captured at acceptance. The extreme byte values 0 and 255 are mixed into the same messages, which stresses the empty-slot and full-slot boundaries next to each other.

// File: rtl/pcount_tx_pkg.sv
package pcount_tx_pkg;
  typedef logic [7:0] val_t;
  localparam int unsigned NUM_VALUES = 5;
  localparam int unsigned NUM_SLOTS  = NUM_VALUES + 1;
  localparam int unsigned SLOT_W     = $clog2(NUM_SLOTS);
endpackage

// File: rtl/pcount_tick_gen.sv
module pcount_tick_gen #(
  parameter int unsigned HALF_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned DIV_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_TICKS - 1);

  logic [DIV_W-1:0] div_q, div_d;

  always_comb begin
    tick_o = run_i && (div_q == DIV_LAST);
    if (!run_i || tick_o) div_d = '0;
    else                  div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R4
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= DIV_LAST);
endmodule

// File: rtl/pcount_slot_seq.sv
module pcount_slot_seq
  import pcount_tx_pkg::*;
#(
  parameter int unsigned FIRST_HALVES = 940,
  parameter int unsigned SLOT_HALVES  = 800,
  localparam int unsigned MAX_HALVES  = (FIRST_HALVES > SLOT_HALVES) ? FIRST_HALVES : SLOT_HALVES,
  localparam int unsigned HALF_W      = $clog2(MAX_HALVES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              tick_i,
  output logic              active_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [HALF_W-1:0] half_o,
  output logic              done_o
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [HALF_W-1:0] FIRST_END = HALF_W'(FIRST_HALVES - 1);
  localparam logic [HALF_W-1:0] SLOT_END  = HALF_W'(SLOT_HALVES - 1);

  logic              active_q, active_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [HALF_W-1:0] half_q, half_d;
  logic              done_q, done_d;
  logic              slot_end;

  always_comb begin
    slot_end = (slot_q == '0) ? (half_q == FIRST_END) : (half_q == SLOT_END);
    active_d = active_q;
    slot_d   = slot_q;
    half_d   = half_q;
    done_d   = 1'b0;
    if (!active_q) begin
      if (accept_i) begin
        active_d = 1'b1;
        slot_d   = '0;
        half_d   = '0;
      end
    end else if (tick_i) begin
      if (slot_end) begin
        half_d = '0;
        if (slot_q == SLOT_LAST) begin
          active_d = 1'b0;
          slot_d   = '0;
          done_d   = 1'b1;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end else begin
        half_d = half_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      half_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      slot_q   <= slot_d;
      half_q   <= half_d;
      done_q   <= done_d;
    end
  end

  assign active_o = active_q;
  assign slot_o   = slot_q;
  assign half_o   = half_q;
  assign done_o   = done_q;

  // R6
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (slot_q <= SLOT_LAST));

  // R10
  done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!active_q && $past(active_q)));
endmodule

// File: rtl/pcount_shaper.sv
module pcount_shaper
  import pcount_tx_pkg::*;
#(
  parameter int unsigned WAKE_PULSES = 5,
  parameter int unsigned HALF_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [HALF_W-1:0] half_i,
  input  val_t              vals_i [NUM_VALUES],
  output logic              line_o
);
  localparam int unsigned CMP_W = (HALF_W > 9) ? HALF_W : 9;

  logic [CMP_W-1:0] pulse_idx;
  logic [CMP_W-1:0] pulse_cnt;

  always_comb begin
    pulse_idx = CMP_W'(half_i >> 1);
    pulse_cnt = CMP_W'(WAKE_PULSES);
    for (int i = 0; i < NUM_VALUES; i++) begin
      if (slot_i == SLOT_W'(i + 1)) pulse_cnt = CMP_W'(vals_i[i]);
    end
    line_o = active_i && !half_i[0] && (pulse_idx < pulse_cnt);
  end

  // R8
  line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_o |-> active_i);
endmodule

// File: rtl/pcount_tx.sv
module pcount_tx
  import pcount_tx_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 50_000_000,
  parameter int unsigned PULSE_HZ     = 2000,
  parameter int unsigned WAKE_PULSES  = 5,
  parameter int unsigned FIRST_HALVES = 940,
  parameter int unsigned SLOT_HALVES  = 800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] dat0_i,
  input  logic [7:0] dat1_i,
  input  logic [7:0] dat2_i,
  input  logic [7:0] sum0_i,
  input  logic [7:0] sum1_i,
  output logic       line_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int unsigned HALF_TICKS = CLK_HZ / (2 * PULSE_HZ);
  localparam int unsigned MAX_HALVES = (FIRST_HALVES > SLOT_HALVES) ? FIRST_HALVES : SLOT_HALVES;
  localparam int unsigned HALF_W     = $clog2(MAX_HALVES);

  if ((CLK_HZ % (2 * PULSE_HZ)) != 0 || HALF_TICKS == 0) begin : g_bad_clock
    $error("CLK_HZ must be a nonzero multiple of twice PULSE_HZ");
  end
  if (SLOT_HALVES < 2 * 255 || FIRST_HALVES < 2 * WAKE_PULSES) begin : g_bad_slot
    $error("slot too short for its largest burst");
  end

  val_t vals_in [NUM_VALUES];
  val_t vals_q  [NUM_VALUES];
  val_t vals_d  [NUM_VALUES];
  logic accept;
  logic tick;
  logic active;
  logic [SLOT_W-1:0] slot;
  logic [HALF_W-1:0] half;

  assign vals_in[0] = dat0_i;
  assign vals_in[1] = dat1_i;
  assign vals_in[2] = dat2_i;
  assign vals_in[3] = sum0_i;
  assign vals_in[4] = sum1_i;

  assign accept = start_i && !active;

  always_comb begin
    for (int i = 0; i < NUM_VALUES; i++) vals_d[i] = accept ? vals_in[i] : vals_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VALUES; i++) vals_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_VALUES; i++) vals_q[i] <= vals_d[i];
    end
  end

  pcount_tick_gen #(.HALF_TICKS(HALF_TICKS)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (active),
    .tick_o (tick)
  );

  pcount_slot_seq #(
    .FIRST_HALVES (FIRST_HALVES),
    .SLOT_HALVES  (SLOT_HALVES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .tick_i   (tick),
    .active_o (active),
    .slot_o   (slot),
    .half_o   (half),
    .done_o   (done_o)
  );

  pcount_shaper #(
    .WAKE_PULSES (WAKE_PULSES),
    .HALF_W      (HALF_W)
  ) u_shape (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (active),
    .slot_i   (slot),
    .half_i   (half),
    .vals_i   (vals_q),
    .line_o   (line_o)
  );

  assign busy_o = active;

  // R9
  vals_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> ($stable(vals_q[0]) && $stable(vals_q[1]) &&
      $stable(vals_q[2]) && $stable(vals_q[3]) && $stable(vals_q[4])));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !active) |=> active);
endmodule

// File: tb/pcount_tx_tb.sv
module pcount_tx_tb;
  localparam int CLK_HZ = 8000;
  localparam int HALF   = 2;
  localparam int FIRSTH = 940;
  localparam int SLOTH  = 800;
  localparam int TOTALH = FIRSTH + 5 * SLOTH;
  localparam int NCYC   = TOTALH * HALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] d0 = '0, d1 = '0, d2 = '0, s0 = '0, s1 = '0;
  logic line, busy, done;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pcount_tx #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .dat0_i(d0), .dat1_i(d1), .dat2_i(d2), .sum0_i(s0), .sum1_i(s1),
    .line_o(line), .busy_o(busy), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int slot_start(input int s);
    return (s == 0) ? 0 : FIRSTH + (s - 1) * SLOTH;
  endfunction

  // one message; inj_c >= 0 raises start and scrambles the inputs at that cycle
  task automatic run_msg(input int v0, v1, v2, v3, v4, input int inj_c);
    int vals[6];
    int rises[6];
    int first_rise[6];
    int bad_hi = 0, bad_lo = 0, bad_busy = 0, bad_done = 0;
    int first_hi = -1, first_lo = -1;
    bit prev = 1'b0;
    vals[0] = 5; vals[1] = v0; vals[2] = v1; vals[3] = v2; vals[4] = v3; vals[5] = v4;
    for (int i = 0; i < 6; i++) begin rises[i] = 0; first_rise[i] = -1; end
    @(negedge clk);
    d0 = 8'(v0); d1 = 8'(v1); d2 = 8'(v2); s0 = 8'(v3); s1 = 8'(v4);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < NCYC; c++) begin
      int g, s, h;
      bit exp_line;
      g = c / HALF;
      s = (g < FIRSTH) ? 0 : 1 + (g - FIRSTH) / SLOTH;
      h = g - slot_start(s);
      exp_line = (h % 2 == 0) && (h / 2 < vals[s]);
      if (line && !exp_line) begin bad_hi++; if (first_hi < 0) first_hi = c; end
      if (!line && exp_line) begin bad_lo++; if (first_lo < 0) first_lo = c; end
      if (!busy) bad_busy++;
      if (done) bad_done++;
      if (line && !prev) begin
        rises[s]++;
        if (first_rise[s] < 0) first_rise[s] = c;
      end
      prev = line;
      if (c == inj_c) begin
        start = 1'b1;
        d0 = ~d0; d1 = d1 + 8'd3; d2 = ~d2; s0 = 8'd200; s1 = 8'd0;
      end
      if (c == inj_c + 1) start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(bad_hi == 0, "R8 line high outside a pulse", first_hi, -1);
    check(bad_lo == 0, "R4 line low inside a pulse", first_lo, -1);
    check(bad_busy == 0, "R2 busy during message", bad_busy, 0);
    check(rises[0] == 5, "R3 wake pulses", rises[0], 5);
    for (int i = 1; i < 6; i++)
      check(rises[i] == vals[i], "R7 pulses per value", rises[i], vals[i]);
    if (vals[1] > 0)
      check(first_rise[1] == FIRSTH * HALF, "R5 first value slot start", first_rise[1], FIRSTH * HALF);
    for (int i = 2; i < 6; i++)
      if (vals[i] > 0)
        check(first_rise[i] == slot_start(i) * HALF, "R6 slot spacing", first_rise[i], slot_start(i) * HALF);
    if (inj_c >= 0) check(bad_hi == 0 && bad_lo == 0, "R9 start during busy ignored", bad_hi + bad_lo, 0);
    check(bad_done == 0, "R10 no early done", bad_done, 0);
    check(done == 1'b1 && busy == 1'b0 && line == 1'b0, "R10 done at end", {done, busy, line}, 3'b100);
    @(negedge clk);
    check(done == 1'b0, "R10 done one cycle", done, 0);
    check(busy == 1'b0 && line == 1'b0, "R8 idle after message", {busy, line}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(line == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 reset state", {line, busy, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(line == 1'b0 && busy == 1'b0, "R8 idle before start", {line, busy}, 0);
    run_msg(28, 1, 174, 9, 37, -1);
    run_msg(0, 0, 0, 0, 0, -1);
    run_msg(255, 255, 255, 255, 255, -1);
    run_msg(1, 2, 3, 4, 5, NCYC - 1);
    run_msg(255, 0, 255, 0, 1, 1500);
    run_msg(254, 128, 127, 64, 2, 7);
    run_msg(0, 255, 0, 255, 0, 4000);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule